// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits between one or more processor request ports and a simple memory interface. It tracks load-exclusive / store-exclusive pairs. For each processor it holds two independent reservations. The first is an address tag, used for regions marked shareable. The second is a bare "reservation outstanding" flag, used for regions that are not shareable. When a store-exclusive arrives, the monitor decides from the matching reservation whether the write may go to memory. It returns a one-bit status, 0 for success and 1 for failure, and on success it consumes the reservation.

Each request carries a processor number, an operation code, a shareable attribute, a base address, an optional immediate offset and write data. The monitor forms the effective address and forwards reads and permitted writes to memory. One cycle later it reports the outcome. Plain stores, and successful store-exclusives, that land in a granule reserved by another processor break that processor's shareable reservation. This is how a lock-claim retry loop learns that it lost a race. Only one request is accepted per cycle.

Top module: `excl_mon`

## Requirements
- R1: While reset is held, and on the first cycle after it, `mem_we`, `mem_re` and `rsp_valid` are 0. Reset drops every reservation, so a store-exclusive issued right after reset fails with status 1 and no write.
- R2: The effective address is `req_base + req_ofs` when `req_ofs_en` is 1, and `req_base` when it is 0. The offset is unsigned and the sum wraps modulo 2^ADDR_W. This address appears on `mem_addr` for every load and every write that goes out.
- R3: A load-exclusive (`req_op` = 2'b10) with `req_shared` = 1 sets the requester's shareable tag to the granule of the effective address. Any tag the requester held before is replaced, so a store-exclusive to the old granule then fails.
- R4: A load-exclusive with `req_shared` = 0 only sets the requester's outstanding flag. It creates no shareable tag, and the later non-shareable store-exclusive makes no address comparison.
- R5: A store-exclusive (`req_op` = 2'b11) with `req_shared` = 0 and the requester's flag set writes memory, returns status 0 and clears the flag.
- R6: A store-exclusive with `req_shared` = 0 and no outstanding flag produces no write and returns status 1.
- R7: A store-exclusive with `req_shared` = 1 whose granule equals the requester's valid tag writes memory, returns status 0 and clears that tag.
- R8: A store-exclusive with `req_shared` = 1 whose granule does not match the requester's tag fails: no write, status 1. This includes a store to an address other than the latest load-exclusive address. A failed store-exclusive leaves the requester's reservations unchanged.
- R9: A plain store (`req_op` = 2'b01), or a successful store-exclusive, clears the shareable tag of every other processor whose tag matches the written granule, whatever `req_shared` says. The writer's own tag is kept on a plain store.
- R10: Tags compare at a granule of 2^GRAN_BITS bytes (default 4). Addresses that differ only in the low GRAN_BITS bits match.
- R11: `rsp_valid` follows `req_valid` by exactly one cycle. `mem_re` is 1 one cycle after a load (2'b00) or load-exclusive, and `rsp_status` is 0 for every operation other than a failed store-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | CPU_W | Requesting processor number |
| req_op | input | 2 | 00 load, 01 store, 10 load-exclusive, 11 store-exclusive |
| req_shared | input | 1 | Target region is shareable |
| req_base | input | ADDR_W | Base address |
| req_ofs_en | input | 1 | Immediate offset present |
| req_ofs | input | OFS_W | Unsigned immediate offset |
| req_wdata | input | DATA_W | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Effective address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| rsp_valid | output | 1 | Status valid |
| rsp_status | output | 1 | 0 success, 1 store-exclusive failed |

## Verification
A corrupted tag, flag or valid bit is invisible until the next store-exclusive from the affected processor. That store then shows a wrong `mem_we` and `rsp_status` one cycle after it is issued. The bench therefore pairs every sweep load-exclusive with later store-exclusives and plain stores from both processors, over a small address window, so each reservation is probed within a few requests. A wrong effective-address or granule computation shows on `mem_addr` in the very next cycle, or as a success or failure flipping on a granule boundary.

// File: rtl/excl_mon_pkg.sv
// Package: shared operation encoding for the exclusive access monitor.
// Assumes the 2-bit opcode layout listed in the brief.
package excl_mon_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LDEX  = 2'b10,
        OP_STEX  = 2'b11
    } op_e;
endpackage

// File: rtl/excl_mon_addr.sv
// Module: excl_mon_addr
// Forms the effective address (base plus optional unsigned offset, wrapping)
// and the granule number used for tag comparison.
// Assumes OFS_W <= ADDR_W and GRAN_BITS < ADDR_W.
module excl_mon_addr #(
    parameter int ADDR_W    = 12,
    parameter int OFS_W     = 4,
    parameter int GRAN_BITS = 2,
    localparam int TAG_W    = ADDR_W - GRAN_BITS
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              ofs_en,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] eff,
    output logic [TAG_W-1:0]  gran
);
    logic [ADDR_W-1:0] ofs_ext;

    // Zero the offset when absent, then widen it to the address width.
    always_comb begin
        ofs_ext = '0;
        if (ofs_en) ofs_ext[OFS_W-1:0] = ofs;
    end

    // Sum and granule extraction.
    always_comb begin
        eff  = base + ofs_ext;
        gran = eff[ADDR_W-1:GRAN_BITS];
    end

    initial begin
        a_r2_ofs_fits : assert (OFS_W <= ADDR_W);
        a_r10_gran_fits : assert (GRAN_BITS < ADDR_W);
    end
endmodule

// File: rtl/excl_mon_slot.sv
// Module: excl_mon_slot
// Reservation state for one processor: a shareable tag with valid bit and a
// separate non-shareable outstanding flag. Also reports whether the current
// request granule matches the held tag.
// Assumes at most one of the set/clear controls targets this slot per cycle,
// except snoop_clr, which never coincides with set_sh.
module excl_mon_slot #(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_sh,
    input  logic             set_ns,
    input  logic             clr_sh,
    input  logic             clr_ns,
    input  logic             snoop_clr,
    input  logic [TAG_W-1:0] req_gran,
    output logic             sh_valid,
    output logic             ns_flag,
    output logic             sh_match
);
    logic [TAG_W-1:0] sh_tag;

    // Shareable reservation: a load-exclusive replaces it; a success or a snoop drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_valid <= 1'b0;
            sh_tag   <= '0;
        end else if (set_sh) begin
            sh_valid <= 1'b1;
            sh_tag   <= req_gran;
        end else if (clr_sh || snoop_clr) begin
            sh_valid <= 1'b0;
        end
    end

    // Non-shareable outstanding flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      ns_flag <= 1'b0;
        else if (set_ns) ns_flag <= 1'b1;
        else if (clr_ns) ns_flag <= 1'b0;
    end

    // Granule compare against the held tag.
    always_comb sh_match = sh_valid && (sh_tag == req_gran);

    a_r1_reset_clears : assert property (@(posedge clk)
        !rst_n |=> (!sh_valid && !ns_flag));
    a_r3_tag_loaded : assert property (@(posedge clk) disable iff (!rst_n)
        set_sh |=> (sh_valid && sh_tag == $past(req_gran)));
    a_r4_flag_set : assert property (@(posedge clk) disable iff (!rst_n)
        set_ns |=> ns_flag);
    a_r9_snoop_drops : assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_clr && !set_sh) |=> !sh_valid);
endmodule

// File: rtl/excl_mon_resp.sv
// Module: excl_mon_resp
// Output register stage: memory strobes, address, data and the status
// response all appear one cycle after the accepted request.
// Assumes the decision inputs are already qualified by request valid.
module excl_mon_resp #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_wr,
    input  logic              in_rd,
    input  logic              in_fail,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rsp_valid,
    output logic              rsp_status
);
    // Control strobes and status, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_status <= 1'b0;
        end else begin
            mem_we     <= in_wr;
            mem_re     <= in_rd;
            rsp_valid  <= in_valid;
            rsp_status <= in_fail;
        end
    end

    // Address and data capture, taken for any accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (in_valid) begin
            mem_addr  <= in_addr;
            mem_wdata <= in_wdata;
        end
    end

    a_r6_fail_no_write : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status |-> (!mem_we && rsp_valid));
    a_r11_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> rsp_valid);
    a_r11_no_rsp_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!rsp_valid && !mem_we && !mem_re));
    a_r11_strobes_excl : assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

// File: rtl/excl_mon.sv
// Module: excl_mon (top)
// Exclusive access monitor: decodes one request per cycle, keeps one
// reservation slot per processor, decides store-exclusive outcome and
// registers the memory strobes and status.
// Assumes req_cpu < NUM_CPU and that stores from outside the monitored
// ports do not exist.
module excl_mon
    import excl_mon_pkg::*;
#(
    parameter int NUM_CPU   = 2,
    parameter int ADDR_W    = 12,
    parameter int OFS_W     = 4,
    parameter int DATA_W    = 32,
    parameter int GRAN_BITS = 2,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int TAG_W    = ADDR_W - GRAN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [1:0]        req_op,
    input  logic              req_shared,
    input  logic [ADDR_W-1:0] req_base,
    input  logic              req_ofs_en,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rsp_valid,
    output logic              rsp_status
);
    op_e               op;
    logic [ADDR_W-1:0] eff_addr;
    logic [TAG_W-1:0]  req_gran;
    logic [NUM_CPU-1:0] cpu_sel, sh_valid, ns_flag, sh_match;
    logic is_ldex, is_stex, is_store, is_load;
    logic own_match, own_ns, stex_ok, wr_go, rd_go;

    excl_mon_addr #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .GRAN_BITS(GRAN_BITS)
    ) u_addr (
        .base(req_base), .ofs_en(req_ofs_en), .ofs(req_ofs),
        .eff(eff_addr), .gran(req_gran)
    );

    // Request decode, qualified by valid.
    always_comb begin
        op       = op_e'(req_op);
        is_load  = req_valid && (op == OP_LOAD);
        is_store = req_valid && (op == OP_STORE);
        is_ldex  = req_valid && (op == OP_LDEX);
        is_stex  = req_valid && (op == OP_STEX);
    end

    // Requester's reservation state, gathered through the one-hot select.
    always_comb begin
        own_match = |(sh_match & cpu_sel);
        own_ns    = |(ns_flag & cpu_sel);
    end

    // Store-exclusive outcome and memory strobe decision.
    always_comb begin
        stex_ok = is_stex && (req_shared ? own_match : own_ns);
        wr_go   = is_store || stex_ok;
        rd_go   = is_load || is_ldex;
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
        logic set_sh_i, set_ns_i, clr_sh_i, clr_ns_i, snoop_i;

        // Per-slot select and control derivation.
        always_comb begin
            cpu_sel[i] = (req_cpu == CPU_W'(i));
            set_sh_i   = is_ldex && req_shared && cpu_sel[i];
            set_ns_i   = is_ldex && !req_shared && cpu_sel[i];
            clr_sh_i   = stex_ok && req_shared && cpu_sel[i];
            clr_ns_i   = stex_ok && !req_shared && cpu_sel[i];
            snoop_i    = wr_go && !cpu_sel[i] && sh_match[i];
        end

        excl_mon_slot #(.TAG_W(TAG_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .set_sh(set_sh_i), .set_ns(set_ns_i),
            .clr_sh(clr_sh_i), .clr_ns(clr_ns_i),
            .snoop_clr(snoop_i), .req_gran(req_gran),
            .sh_valid(sh_valid[i]), .ns_flag(ns_flag[i]),
            .sh_match(sh_match[i])
        );
    end

    excl_mon_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_wr(wr_go), .in_rd(rd_go),
        .in_fail(is_stex && !stex_ok),
        .in_addr(eff_addr), .in_wdata(req_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status)
    );

    a_r5_ns_success : assert property (@(posedge clk) disable iff (!rst_n)
        (is_stex && !req_shared && own_ns) |=> (mem_we && !rsp_status));
    a_r6_ns_failure : assert property (@(posedge clk) disable iff (!rst_n)
        (is_stex && !req_shared && !own_ns) |=> (!mem_we && rsp_status));
    a_r7_sh_success : assert property (@(posedge clk) disable iff (!rst_n)
        (is_stex && req_shared && own_match) |=> (mem_we && !rsp_status));
    a_r8_sh_failure : assert property (@(posedge clk) disable iff (!rst_n)
        (is_stex && req_shared && !own_match) |=> (!mem_we && rsp_status));
    a_r11_one_cpu : assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot(cpu_sel));
endmodule

// File: tb/excl_mon_tb_top.sv
`timescale 1ns/1ps
module excl_mon_tb_top;
    localparam int NCPU   = 2;
    localparam int AW     = 12;
    localparam int OW     = 4;
    localparam int DW     = 32;
    localparam int GB     = 2;
    localparam int TW     = AW - GB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [0:0]    req_cpu = '0;
    logic [1:0]    req_op = '0;
    logic          req_shared = 1'b0;
    logic [AW-1:0] req_base = '0;
    logic          req_ofs_en = 1'b0;
    logic [OW-1:0] req_ofs = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          mem_we, mem_re, rsp_valid, rsp_status;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int checks = 0;
    int fails  = 0;

    // Bench reservation model
    logic          m_shv [NCPU];
    logic [TW-1:0] m_tag [NCPU];
    logic          m_ns  [NCPU];

    always #2 clk = ~clk;

    excl_mon #(.NUM_CPU(NCPU), .ADDR_W(AW), .OFS_W(OW), .DATA_W(DW), .GRAN_BITS(GB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpu(req_cpu),
        .req_op(req_op), .req_shared(req_shared), .req_base(req_base),
        .req_ofs_en(req_ofs_en), .req_ofs(req_ofs), .req_wdata(req_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCPU; c++) begin
            m_shv[c] = 1'b0; m_tag[c] = '0; m_ns[c] = 1'b0;
        end
    endtask

    // Issue one request, predict from the model, check one cycle later.
    task automatic do_req(input string tag, input int cpu, input int op, input bit sh,
                          input int base, input bit oen, input int ofs, input int wd);
        logic [AW-1:0] e;
        logic [TW-1:0] g;
        bit ok, we, re, st;
        e  = AW'(base) + (oen ? AW'(ofs) : AW'(0));
        g  = e[AW-1:GB];
        ok = 1'b0;
        if (op == 3) ok = sh ? (m_shv[cpu] && m_tag[cpu] == g) : m_ns[cpu];
        we = (op == 1) || ok;
        re = (op == 0) || (op == 2);
        st = (op == 3) && !ok;
        @(negedge clk);
        req_valid = 1'b1; req_cpu = 1'(cpu); req_op = 2'(op); req_shared = sh;
        req_base = AW'(base); req_ofs_en = oen; req_ofs = OW'(ofs); req_wdata = DW'(wd);
        // model update
        if (op == 2) begin
            if (sh) begin m_shv[cpu] = 1'b1; m_tag[cpu] = g; end
            else m_ns[cpu] = 1'b1;
        end
        if (ok) begin
            if (sh) m_shv[cpu] = 1'b0; else m_ns[cpu] = 1'b0;
        end
        if (we) for (int c = 0; c < NCPU; c++)
            if (c != cpu && m_shv[c] && m_tag[c] == g) m_shv[c] = 1'b0;
        @(posedge clk);
        #1;
        chk(tag, "rsp_valid", rsp_valid, 1);
        chk(tag, "mem_we", mem_we, we);
        chk(tag, "mem_re", mem_re, re);
        chk(tag, "rsp_status", rsp_status, st);
        if (we || re) chk(tag, "mem_addr", mem_addr, e);
        if (we) chk(tag, "mem_wdata", mem_wdata, DW'(wd));
    endtask

    task automatic idle_chk(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(tag, "idle rsp_valid", rsp_valid, 0);
        chk(tag, "idle mem_we", mem_we, 0);
        chk(tag, "idle mem_re", mem_re, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        // R1: requests during reset are ignored
        req_valid = 1'b1; req_op = 2'b01;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset rsp_valid", rsp_valid, 0);
        chk("R1", "reset mem_we", mem_we, 0);
        chk("R1", "reset mem_re", mem_re, 0);
        @(negedge clk);
        rst_n = 1'b1; req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "post-reset rsp_valid", rsp_valid, 0);
        chk("R1", "post-reset mem_we", mem_we, 0);
        do_req("R1", 0, 3, 1, 'h40, 0, 0, 'h11);     // no reservation after reset
        do_req("R1", 1, 3, 0, 'h40, 0, 0, 'h12);

        // R2/R3/R7: offset forms address; tag consumed on success
        do_req("R2", 0, 2, 1, 'h40, 1, 4, 0);         // eff 0x44
        do_req("R7", 0, 3, 1, 'h44, 0, 7, 'hA5);      // offset ignored when absent
        do_req("R7", 0, 3, 1, 'h44, 0, 0, 'hA6);      // tag was cleared
        do_req("R2", 1, 0, 0, 'hFFE, 1, 5, 0);        // wraps to 0x003

        // R3/R10: replacement and granule match
        do_req("R3", 0, 2, 1, 'h80, 0, 0, 0);
        do_req("R3", 0, 2, 1, 'h90, 0, 0, 0);
        do_req("R3", 0, 3, 1, 'h80, 0, 0, 'h1);       // old granule fails
        do_req("R10", 0, 3, 1, 'h90, 1, 3, 'h2);      // 0x93 same granule
        do_req("R10", 1, 2, 1, 'hA0, 0, 0, 0);
        do_req("R10", 1, 3, 1, 'hA4, 0, 0, 'h3);      // next granule fails

        // R4/R5/R6: non-shareable flag, no address compare
        do_req("R4", 1, 2, 0, 'h10, 0, 0, 0);
        do_req("R5", 1, 3, 0, 'h300, 0, 0, 'h55);
        do_req("R6", 1, 3, 0, 'h10, 0, 0, 'h56);
        do_req("R4", 0, 2, 0, 'h10, 0, 0, 0);
        do_req("R4", 0, 3, 1, 'h10, 0, 0, 'h57);      // no shareable tag made
        do_req("R5", 0, 3, 0, 'h10, 0, 0, 'h58);

        // R9: plain store and successful store-exclusive break others
        do_req("R9", 0, 2, 1, 'h20, 0, 0, 0);
        do_req("R9", 1, 2, 1, 'h20, 0, 0, 0);
        do_req("R9", 1, 1, 0, 'h21, 0, 0, 'h77);      // attribute 0 still snoops
        do_req("R9", 0, 3, 1, 'h20, 0, 0, 'h78);      // broken
        do_req("R9", 1, 3, 1, 'h20, 0, 0, 'h79);      // own tag kept
        do_req("R9", 0, 2, 1, 'h50, 0, 0, 0);
        do_req("R9", 1, 2, 1, 'h50, 0, 0, 0);
        do_req("R9", 0, 3, 1, 'h50, 0, 0, 'h7A);
        do_req("R9", 1, 3, 1, 'h50, 0, 0, 'h7B);

        // R8: other address fails and keeps the reservation
        do_req("R8", 1, 2, 1, 'h60, 0, 0, 0);
        do_req("R8", 1, 3, 1, 'h64, 0, 0, 'h81);
        do_req("R8", 1, 3, 1, 'h60, 0, 0, 'h82);

        // R11: response timing and idle
        do_req("R11", 0, 0, 1, 'h70, 0, 0, 0);
        idle_chk("R11");
        do_req("R11", 1, 1, 1, 'h74, 1, 1, 'h99);

        // Near-exhaustive sweep over a small window, both CPUs, all ops
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            int op, cpu;
            string t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op  = int'(lfsr[1:0]);
            cpu = int'(lfsr[2]);
            case (op)
                0: t = "R2";
                1: t = "R9";
                2: t = "R3";
                default: t = lfsr[3] ? "R7" : "R5";
            endcase
            do_req(t, cpu, op, lfsr[3], int'(lfsr[8:4]), lfsr[9], int'(lfsr[11:10]), int'(lfsr));
            if (lfsr[15:12] == 4'h0) idle_chk("R11");
        end

        @(negedge clk);
        req_valid = 1'b0;
        summary();
        $finish;
    end
endmodule